// File: doc/BRIEF.md
# Protected Return Address Stack

This block keeps subroutine return addresses in a dedicated hardware LIFO that is physically apart from the data stack holding local variables. An overrun of a buffer in a stack frame therefore has no path to a return address. The core's decoder presents one strobe per operation: call, return, dedicated push, dedicated pop, and an ordinary store whose address falls in the protected region. With those strobes it supplies the call's next-PC, and for a dedicated push an operand together with its type tag.

A call pushes its next-PC without a separate instruction. A return pops the top entry and hands it back as the next program counter. A dedicated push and a dedicated pop are the only other operations that may change the contents. A dedicated push succeeds only when its operand is tagged as an address. Every refused operation leaves the storage untouched and raises exactly one fault pulse: access, type, overflow or underflow.

Top module: `prot_ret_stack`

## Requirements
- R1: A call strobe on its own, with fewer than DEPTH entries held, stores `call_npc_i` as the new top entry.
- R2: A return or dedicated pop on its own, with at least one entry held, removes the top entry. In the next cycle that entry appears on `ret_addr_o` with `ret_valid_o` high, so entries come back in last-in, first-out order.
- R3: A dedicated push on its own, with `push_tag_i` equal to ADDR_TAG (default 2'b01) and fewer than DEPTH entries held, stores `push_data_i` as the new top entry.
- R4: A stack-region store strobe on its own raises `access_fault_o` in the next cycle and changes no entry and no depth.
- R5: A dedicated push whose tag differs from ADDR_TAG raises `type_fault_o` in the next cycle and stores nothing.
- R6: A call or an address-tagged push made while DEPTH entries are held raises `overflow_o` in the next cycle. No entry is overwritten, including the oldest.
- R7: A return or dedicated pop made while the stack is empty raises `underflow_o` in the next cycle, with `ret_addr_o` zero and `ret_valid_o` low.
- R8: When two or more of the five strobes are high in one cycle, `access_fault_o` is raised in the next cycle and none of the operations is carried out.
- R9: Asserting `rst_ni` low empties the stack and drives every output to zero.
- R10: The fault outputs and `ret_valid_o` are single-cycle results of the previous cycle's strobes. At most one of them is high at a time, and all of them are low after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe (implicit push of next-PC) |
| ret_i | input | 1 | Return strobe (implicit pop) |
| push_i | input | 1 | Dedicated push strobe |
| pop_i | input | 1 | Dedicated pop strobe |
| stk_wr_i | input | 1 | Ordinary store aimed at the protected region |
| push_data_i | input | AW | Operand of a dedicated push |
| push_tag_i | input | TAG_W | Type tag of the push operand |
| call_npc_i | input | AW | Return address pushed by a call |
| ret_addr_o | output | AW | Popped entry, zero when no valid pop |
| ret_valid_o | output | 1 | Popped entry valid |
| access_fault_o | output | 1 | Illegal write or conflicting strobes |
| type_fault_o | output | 1 | Push operand not tagged as an address |
| overflow_o | output | 1 | Push or call with the stack full |
| underflow_o | output | 1 | Pop or return with the stack empty |

## Verification
Every result is registered, so each output belongs to the strobes of exactly one earlier cycle and is due one clock edge after them. The bench drives inputs on the falling edge and samples two nanoseconds after the following rising edge. Before that edge it computes the expected outputs from its own model of the stack, so every comparison covers exactly one operation. Contents left untouched by refused operations are confirmed through later pops, which must still return the model's entries.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    FLT_NONE,
    FLT_ACCESS,
    FLT_TYPE,
    FLT_OVER,
    FLT_UNDER
  } flt_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int unsigned TAG_W = 2,
  parameter logic [TAG_W-1:0] ADDR_TAG = TAG_W'(1)
) (
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             stk_wr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             full_i,
  input  logic             empty_i,
  output logic             wr_o,
  output logic             rd_o,
  output logic             sel_call_o,
  output ras_pkg::flt_e    flt_o
);
  import ras_pkg::*;

  logic [2:0] n_stb;
  assign n_stb = 3'($countones({call_i, ret_i, push_i, pop_i, stk_wr_i}));

  always_comb begin
    wr_o       = 1'b0;
    rd_o       = 1'b0;
    sel_call_o = 1'b0;
    flt_o      = FLT_NONE;
    if (n_stb > 3'd1) begin
      flt_o = FLT_ACCESS;
    end else if (stk_wr_i) begin
      flt_o = FLT_ACCESS;
    end else if (call_i) begin
      if (full_i) flt_o = FLT_OVER;
      else begin
        wr_o       = 1'b1;
        sel_call_o = 1'b1;
      end
    end else if (push_i) begin
      if (tag_i != ADDR_TAG) flt_o = FLT_TYPE;
      else if (full_i)       flt_o = FLT_OVER;
      else                   wr_o  = 1'b1;
    end else if (ret_i || pop_i) begin
      if (empty_i) flt_o = FLT_UNDER;
      else         rd_o  = 1'b1;
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 32,
  localparam int unsigned SPW  = $clog2(DEPTH + 1),
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [AW-1:0]  wdata_i,
  output logic [AW-1:0]  top_o,
  output logic           full_o,
  output logic           empty_o,
  output logic [SPW-1:0] sp_o
);
  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [IDXW-1:0] wr_idx, top_idx;

  assign wr_idx  = IDXW'(sp_q);
  assign top_idx = IDXW'(sp_q - SPW'(1));
  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign top_o   = empty_o ? '0 : mem[top_idx];
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sp_q <= '0;
    else if (wr_i && !full_o)       sp_q <= sp_q + SPW'(1);
    else if (rd_i && !empty_o)      sp_q <= sp_q - SPW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_i && !full_o && wr_idx == IDXW'(g)) mem[g] <= wdata_i;
    end
  end

  AST_SP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SPW'(DEPTH)); // R6
endmodule

// File: rtl/ras_out.sv
module ras_out #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] top_i,
  input  ras_pkg::flt_e flt_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          ret_valid_o,
  output logic          access_fault_o,
  output logic          type_fault_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  import ras_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_addr_o     <= '0;
      ret_valid_o    <= 1'b0;
      access_fault_o <= 1'b0;
      type_fault_o   <= 1'b0;
      overflow_o     <= 1'b0;
      underflow_o    <= 1'b0;
    end else begin
      ret_addr_o     <= rd_i ? top_i : '0;
      ret_valid_o    <= rd_i;
      access_fault_o <= (flt_i == FLT_ACCESS);
      type_fault_o   <= (flt_i == FLT_TYPE);
      overflow_o     <= (flt_i == FLT_OVER);
      underflow_o    <= (flt_i == FLT_UNDER);
    end
  end

  AST_UNDER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (!ret_valid_o && ret_addr_o == '0)); // R7
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ret_valid_o, access_fault_o, type_fault_o, overflow_o, underflow_o})); // R10
endmodule

// File: rtl/prot_ret_stack.sv
module prot_ret_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 32,
  parameter int unsigned TAG_W = 2,
  parameter logic [TAG_W-1:0] ADDR_TAG = TAG_W'(1),
  localparam int unsigned SPW  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             stk_wr_i,
  input  logic [AW-1:0]    push_data_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic [AW-1:0]    call_npc_i,
  output logic [AW-1:0]    ret_addr_o,
  output logic             ret_valid_o,
  output logic             access_fault_o,
  output logic             type_fault_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  import ras_pkg::*;

  logic          wr, rd, sel_call, full, empty;
  flt_e          flt;
  logic [AW-1:0] wdata, top;
  logic [SPW-1:0] sp;

  ras_ctrl #(.TAG_W(TAG_W), .ADDR_TAG(ADDR_TAG)) u_ctrl (
    .call_i(call_i), .ret_i(ret_i), .push_i(push_i), .pop_i(pop_i),
    .stk_wr_i(stk_wr_i), .tag_i(push_tag_i), .full_i(full), .empty_i(empty),
    .wr_o(wr), .rd_o(rd), .sel_call_o(sel_call), .flt_o(flt)
  );

  assign wdata = sel_call ? call_npc_i : push_data_i;

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .top_o(top), .full_o(full), .empty_o(empty), .sp_o(sp)
  );

  ras_out #(.AW(AW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd), .top_i(top), .flt_i(flt),
    .ret_addr_o(ret_addr_o), .ret_valid_o(ret_valid_o),
    .access_fault_o(access_fault_o), .type_fault_o(type_fault_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  AST_ACCESS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_fault_o |-> sp == $past(sp)); // R4
  AST_TYPE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_fault_o |-> sp == $past(sp)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (sp == $past(sp) && sp == SPW'(DEPTH))); // R6
  AST_POP_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> $past(sp) == sp + SPW'(1)); // R2
  AST_MULTI_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({call_i, ret_i, push_i, pop_i, stk_wr_i}) > 1) |=> access_fault_o); // R8
endmodule

// File: tb/prot_ret_stack_test.sv
module prot_ret_stack_test;
  localparam int DEPTH = 16;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_s = 0, ret_s = 0, push_s = 0, pop_s = 0, wr_s = 0;
  logic [AW-1:0] pdata = '0, npc = '0;
  logic [1:0] ptag = '0;
  logic [AW-1:0] ret_addr;
  logic ret_valid, acc_f, typ_f, ovf, unf;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] mdl [DEPTH];
  int mcnt = 0;

  always #4 clk = ~clk;

  prot_ret_stack uut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call_s), .ret_i(ret_s), .push_i(push_s),
    .pop_i(pop_s), .stk_wr_i(wr_s), .push_data_i(pdata), .push_tag_i(ptag),
    .call_npc_i(npc), .ret_addr_o(ret_addr), .ret_valid_o(ret_valid),
    .access_fault_o(acc_f), .type_fault_o(typ_f), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic compare(string req, logic [AW-1:0] ea, logic ev, logic ea_f,
                         logic et, logic eo, logic eu);
    n_chk++;
    if (ret_addr !== ea || ret_valid !== ev || acc_f !== ea_f || typ_f !== et ||
        ovf !== eo || unf !== eu) begin
      n_bad++;
      $display("FAIL %s: got addr=%h v=%b acc=%b typ=%b ovf=%b unf=%b exp addr=%h v=%b acc=%b typ=%b ovf=%b unf=%b",
               req, ret_addr, ret_valid, acc_f, typ_f, ovf, unf, ea, ev, ea_f, et, eo, eu);
    end
  endtask

  // drive one cycle at the falling edge, check one edge later
  task automatic step(logic c, logic r, logic p, logic q, logic s,
                      logic [AW-1:0] d, logic [1:0] t, logic [AW-1:0] a);
    string req = "R10";
    logic [AW-1:0] e_addr = '0;
    logic e_v = 0, e_acc = 0, e_typ = 0, e_ovf = 0, e_unf = 0;
    int n = int'(c) + int'(r) + int'(p) + int'(q) + int'(s);
    call_s = c; ret_s = r; push_s = p; pop_s = q; wr_s = s;
    pdata = d; ptag = t; npc = a;
    if (n > 1) begin e_acc = 1; req = "R8"; end
    else if (s) begin e_acc = 1; req = "R4"; end
    else if (c) begin
      if (mcnt == DEPTH) begin e_ovf = 1; req = "R6"; end
      else begin mdl[mcnt] = a; mcnt++; req = "R1"; end
    end else if (p) begin
      if (t != 2'b01) begin e_typ = 1; req = "R5"; end
      else if (mcnt == DEPTH) begin e_ovf = 1; req = "R6"; end
      else begin mdl[mcnt] = d; mcnt++; req = "R3"; end
    end else if (r || q) begin
      if (mcnt == 0) begin e_unf = 1; req = "R7"; end
      else begin mcnt--; e_addr = mdl[mcnt]; e_v = 1; req = "R2"; end
    end
    @(posedge clk); #2;
    compare(req, e_addr, e_v, e_acc, e_typ, e_ovf, e_unf);
    @(negedge clk);
    call_s = 0; ret_s = 0; push_s = 0; pop_s = 0; wr_s = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    mcnt = 0;
    repeat (2) @(negedge clk);
    compare("R9", '0, 0, 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    compare("R9", '0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    step(0, 1, 0, 0, 0, '0, 0, '0);                    // R9 empty after reset -> R7
    step(0, 0, 0, 0, 0, '0, 0, '0);                    // R10 idle
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, 0, 0, '0, 0, 32'h1000 + i);        // R1 fill
    step(1, 0, 0, 0, 0, '0, 0, 32'hdead);              // R6 call when full
    step(0, 0, 1, 0, 0, 32'hbeef, 2'b01, '0);          // R6 push when full
    step(0, 0, 0, 0, 1, '0, 0, '0);                    // R4
    step(1, 1, 0, 0, 0, '0, 0, 32'h7);                 // R8
    for (int i = 0; i < DEPTH; i++)
      step(0, i[0], 0, !i[0], 0, '0, 0, '0);           // R2 LIFO drain, oldest intact
    step(0, 0, 0, 1, 0, '0, 0, '0);                    // R7
    step(0, 0, 1, 0, 0, 32'h55, 2'b10, '0);            // R5
    step(0, 0, 1, 0, 0, 32'h66, 2'b00, '0);            // R5
    step(0, 0, 1, 0, 0, 32'h77, 2'b01, '0);            // R3
    step(0, 0, 1, 1, 0, 32'h88, 2'b01, '0);            // R8
    step(0, 0, 0, 0, 1, '0, 0, '0);                    // R4
    step(0, 1, 0, 0, 0, '0, 0, '0);                    // R2 returns 0x77
    step(0, 0, 1, 0, 0, 32'h99, 2'b01, '0);
    do_reset();                                        // R9 mid-run
    step(0, 0, 0, 1, 0, '0, 0, '0);                    // R9/R7
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom_range(0, 99);
      logic c = 0, r = 0, p = 0, q = 0, s = 0;
      bit bias_push = ((i / 200) % 2) == 0;
      if (k < 3) begin c = 1; r = 1'($urandom); p = 1; end
      else if (k < 7) s = 1;
      else if (k < 15) ;
      else if (k < 55) begin
        if (bias_push) begin if (k[0]) c = 1; else p = 1; end
        else begin if (k[0]) r = 1; else q = 1; end
      end else if (k < 80) begin if (k[0]) c = 1; else p = 1; end
      else begin if (k[0]) r = 1; else q = 1; end
      step(c, r, p, q, s, $urandom, ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b01,
           $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule